// File: doc/BRIEF.md
# AHB Burst Slave Address Sequencer

This block is the bus-facing front end of a memory slave that serves one AHB-Lite master. It watches the address phase of every transfer, decides whether a beat is taken, and works out the byte address of each beat of a burst by itself, for incrementing and wrapping bursts of one, four, eight or sixteen beats and for incrementing bursts of open length. The master's address is used only on the first beat of a burst; the following beats are produced by the block's own generator.

Accepted beats go into the data phase. A write beat hands its address, size and write data to a write queue. A read beat first posts a request (address and size) to a read-request queue and then waits for the answer in a read-data queue. All three queues sit on the far side of a clock crossing and show only full or empty flags. The block holds HREADY low for as long as the queue it needs cannot take or give a beat, so the bus stalls exactly as long as the slow side needs.

Top module: `burst_slave_seq`

## Requirements
- R1: While reset is held and directly after it, hready is high and wq_push, rreq_push and rdat_pop are low.
- R2: The hburst code sets the beat count: 000 gives 1 beat, 001 gives an open length, 010 and 011 give 4, 100 and 101 give 8, 110 and 111 give 16; odd codes increment, even codes other than 000 wrap. A SEQ beyond the beat count of a fixed-length burst is not taken.
- R3: hsize 000, 001 and 010 select 1, 2 and 4 byte beats; a NONSEQ or SEQ with any hsize above 010 is not taken and ends the running burst.
- R4: In an incrementing burst each beat address is the previous beat address plus the beat size in bytes.
- R5: In a wrapping burst the address region is beats times size bytes, aligned to that size; each beat adds the size and wraps back to the region base, so only the bits inside the region change.
- R6: haddr is loaded only on NONSEQ; on SEQ beats haddr is ignored. A NONSEQ in the middle of a burst starts a new burst from its own address and count.
- R7: htrans BUSY takes no beat and leaves the next address unchanged; htrans IDLE takes no beat and ends the burst, so a later SEQ is not taken.
- R8: A write data phase pushes one write-queue entry (generated address, size, hwdata) in a cycle where wq_full is low; while wq_full is high hready is low and nothing is pushed.
- R9: A read data phase posts exactly one read request (address, size) in the first cycle with rreq_full low, then holds hready low until rdat_empty is low; in that cycle rdat_pop is high and hrdata equals rdat_data.
- R10: A transfer is taken only when hsel and hready are both high in its address phase; with hsel low nothing reaches any queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select |
| htrans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| hburst | input | 3 | Burst type code |
| hsize | input | 3 | Beat size code |
| hwrite | input | 1 | High for a write beat |
| haddr | input | ADDR_W | Byte address, used on NONSEQ |
| hwdata | input | DATA_W | Write data in the data phase |
| hready | output | 1 | Current data phase completes this cycle |
| hrdata | output | DATA_W | Read data, valid with hready in a read data phase |
| wq_push | output | 1 | Write-queue push strobe |
| wq_addr | output | ADDR_W | Address of the pushed write beat |
| wq_data | output | DATA_W | Data of the pushed write beat |
| wq_size | output | 3 | Size code of the pushed write beat |
| wq_full | input | 1 | Write queue cannot take an entry |
| rreq_push | output | 1 | Read-request push strobe |
| rreq_addr | output | ADDR_W | Address of the requested read beat |
| rreq_size | output | 3 | Size code of the requested read beat |
| rreq_full | input | 1 | Read-request queue cannot take an entry |
| rdat_pop | output | 1 | Read-data pop strobe |
| rdat_data | input | DATA_W | Head of the read-data queue |
| rdat_empty | input | 1 | Read-data queue holds nothing |

## Verification
The bench builds the block with a 32-bit address and a 32-bit data bus. The full word size is therefore legal, so a 16-beat word wrap spans a 64-byte region and size codes above word can be shown to be refused. The wide address lets a wrapping burst start eight bytes below the top of the address space, where a plain increment would roll over and only a correct wrap stays in its region. The bench drives junk on haddr during SEQ beats, so every address it checks comes from the generator.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  typedef enum logic [1:0] {
    DP_NONE,
    DP_WRITE,
    DP_RDREQ,
    DP_RDWAIT
  } dphase_e;

  // Control carried from address phase into data phase.
  typedef struct packed {
    logic       write;
    logic [2:0] size;
  } beat_ctl_t;

  // Beats per burst; zero means open length.
  function automatic logic [4:0] burst_beats(input logic [2:0] code);
    case (code)
      3'd0:       return 5'd1;
      3'd1:       return 5'd0;
      3'd2, 3'd3: return 5'd4;
      3'd4, 3'd5: return 5'd8;
      default:    return 5'd16;
    endcase
  endfunction

  // Even nonzero codes wrap.
  function automatic logic burst_wraps(input logic [2:0] code);
    return (code != 3'd0) && !code[0];
  endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic              bus_ready,
  input  logic [1:0]        htrans,
  input  logic [2:0]        hburst,
  input  logic [2:0]        hsize,
  input  logic              hwrite,
  input  logic [ADDR_W-1:0] haddr,
  input  logic              size_ok,
  output logic              beat_accept,
  output logic              seq_accept,
  output logic [ADDR_W-1:0] beat_addr,
  output burst_pkg::beat_ctl_t beat_ctl,
  output logic [ADDR_W-1:0] prev_addr,
  output logic [2:0]        run_size,
  output logic [2:0]        run_burst
);
  import burst_pkg::*;

  localparam int CNT_W = 5;

  function automatic logic [ADDR_W-1:0] step_addr(
    input logic [ADDR_W-1:0] a,
    input logic [2:0]        sz,
    input logic [2:0]        code
  );
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] msk;
    step = ADDR_W'(1) << sz;
    span = ADDR_W'(burst_beats(code)) << sz;
    msk  = span - ADDR_W'(1);
    if (burst_wraps(code)) return (a & ~msk) | ((a + step) & msk);
    else                   return a + step;
  endfunction

  logic              run_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        size_q;
  logic [2:0]        burst_q;
  logic [CNT_W-1:0]  cnt_q;

  logic              slot;
  logic              is_ns;
  logic              is_sq;
  logic [CNT_W-1:0]  len;
  logic              seq_room;
  logic              ns_accept;
  logic              ends_burst;
  logic [ADDR_W-1:0] next_addr;

  always_comb begin
    slot       = hsel && bus_ready;
    is_ns      = (htrans == TR_NONSEQ);
    is_sq      = (htrans == TR_SEQ);
    len        = burst_beats(burst_q);
    seq_room   = run_q && ((len == '0) || (cnt_q < len));
    ns_accept  = slot && is_ns && size_ok;
    seq_accept = slot && is_sq && size_ok && seq_room;
    beat_accept = ns_accept || seq_accept;
    next_addr  = step_addr(addr_q, size_q, burst_q);
    beat_addr  = ns_accept ? haddr : next_addr;
    beat_ctl.write = hwrite;
    beat_ctl.size  = ns_accept ? hsize : size_q;
    ends_burst = bus_ready &&
                 (!hsel || (htrans == TR_IDLE) || (htrans[1] && !size_ok));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      burst_q <= '0;
      cnt_q   <= '0;
    end else if (ns_accept) begin
      run_q   <= 1'b1;
      addr_q  <= haddr;
      size_q  <= hsize;
      burst_q <= hburst;
      cnt_q   <= CNT_W'(1);
    end else if (seq_accept) begin
      addr_q <= next_addr;
      if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + CNT_W'(1);
    end else if (ends_burst) begin
      run_q <= 1'b0;
    end
  end

  assign prev_addr = addr_q;
  assign run_size  = size_q;
  assign run_burst = burst_q;

endmodule

// File: rtl/burst_dphase.sv
module burst_dphase #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_accept,
  input  logic [ADDR_W-1:0] beat_addr,
  input  burst_pkg::beat_ctl_t beat_ctl,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              wq_full,
  input  logic              rreq_full,
  input  logic              rdat_empty,
  input  logic [DATA_W-1:0] rdat_data,
  output logic              hready,
  output logic [DATA_W-1:0] hrdata,
  output logic              wq_push,
  output logic [ADDR_W-1:0] wq_addr,
  output logic [DATA_W-1:0] wq_data,
  output logic [2:0]        wq_size,
  output logic              rreq_push,
  output logic [ADDR_W-1:0] rreq_addr,
  output logic [2:0]        rreq_size,
  output logic              rdat_pop,
  output burst_pkg::dphase_e dp_state
);
  import burst_pkg::*;

  dphase_e           st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        size_q;

  always_comb begin
    hready    = 1'b1;
    wq_push   = 1'b0;
    rreq_push = 1'b0;
    rdat_pop  = 1'b0;
    hrdata    = '0;
    case (st_q)
      DP_WRITE: begin
        hready  = !wq_full;
        wq_push = !wq_full;
      end
      DP_RDREQ: begin
        hready    = 1'b0;
        rreq_push = !rreq_full;
      end
      DP_RDWAIT: begin
        hready   = !rdat_empty;
        rdat_pop = !rdat_empty;
        hrdata   = rdat_data;
      end
      default: hready = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DP_NONE;
      addr_q <= '0;
      size_q <= '0;
    end else if (hready) begin
      if (beat_accept) begin
        st_q   <= beat_ctl.write ? DP_WRITE : DP_RDREQ;
        addr_q <= beat_addr;
        size_q <= beat_ctl.size;
      end else begin
        st_q <= DP_NONE;
      end
    end else if ((st_q == DP_RDREQ) && !rreq_full) begin
      st_q <= DP_RDWAIT;
    end
  end

  assign wq_addr   = addr_q;
  assign wq_data   = hwdata;
  assign wq_size   = size_q;
  assign rreq_addr = addr_q;
  assign rreq_size = size_q;
  assign dp_state  = st_q;

endmodule

// File: rtl/burst_slave_seq.sv
module burst_slave_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic [1:0]        htrans,
  input  logic [2:0]        hburst,
  input  logic [2:0]        hsize,
  input  logic              hwrite,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [DATA_W-1:0] hwdata,
  output logic              hready,
  output logic [DATA_W-1:0] hrdata,
  output logic              wq_push,
  output logic [ADDR_W-1:0] wq_addr,
  output logic [DATA_W-1:0] wq_data,
  output logic [2:0]        wq_size,
  input  logic              wq_full,
  output logic              rreq_push,
  output logic [ADDR_W-1:0] rreq_addr,
  output logic [2:0]        rreq_size,
  input  logic              rreq_full,
  output logic              rdat_pop,
  input  logic [DATA_W-1:0] rdat_data,
  input  logic              rdat_empty
);
  import burst_pkg::*;

  localparam int LANE_LOG = $clog2(DATA_W / 8);
  localparam int SIZE_TOP = (LANE_LOG > 2) ? 2 : LANE_LOG;

  // Named internal events, visible to the bound checker.
  logic              size_ok;
  logic              beat_accept;
  logic              seq_accept;
  logic [ADDR_W-1:0] beat_addr;
  beat_ctl_t         beat_ctl;
  logic [ADDR_W-1:0] gen_prev_addr;
  logic [2:0]        gen_size;
  logic [2:0]        gen_burst;
  dphase_e           dp_state;

  assign size_ok = (hsize <= 3'(SIZE_TOP));

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_gen (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsel        (hsel),
    .bus_ready   (hready),
    .htrans      (htrans),
    .hburst      (hburst),
    .hsize       (hsize),
    .hwrite      (hwrite),
    .haddr       (haddr),
    .size_ok     (size_ok),
    .beat_accept (beat_accept),
    .seq_accept  (seq_accept),
    .beat_addr   (beat_addr),
    .beat_ctl    (beat_ctl),
    .prev_addr   (gen_prev_addr),
    .run_size    (gen_size),
    .run_burst   (gen_burst)
  );

  burst_dphase #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat_accept (beat_accept),
    .beat_addr   (beat_addr),
    .beat_ctl    (beat_ctl),
    .hwdata      (hwdata),
    .wq_full     (wq_full),
    .rreq_full   (rreq_full),
    .rdat_empty  (rdat_empty),
    .rdat_data   (rdat_data),
    .hready      (hready),
    .hrdata      (hrdata),
    .wq_push     (wq_push),
    .wq_addr     (wq_addr),
    .wq_data     (wq_data),
    .wq_size     (wq_size),
    .rreq_push   (rreq_push),
    .rreq_addr   (rreq_addr),
    .rreq_size   (rreq_size),
    .rdat_pop    (rdat_pop),
    .dp_state    (dp_state)
  );

endmodule

// File: rtl/burst_slave_seq_chk.sv
module burst_slave_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsel,
  input logic [1:0]        htrans,
  input logic [2:0]        hsize,
  input logic              hready,
  input logic              wq_push,
  input logic              wq_full,
  input logic              rreq_push,
  input logic              rreq_full,
  input logic              rdat_pop,
  input logic              rdat_empty,
  input logic              beat_accept,
  input logic              seq_accept,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [ADDR_W-1:0] gen_prev_addr,
  input logic [2:0]        gen_size,
  input logic [2:0]        gen_burst,
  input burst_pkg::dphase_e dp_state
);
  import burst_pkg::*;

  logic [ADDR_W-1:0] span;
  assign span = ADDR_W'(burst_beats(gen_burst)) << gen_size;

  // R8
  wq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wq_push |-> !wq_full);

  // R8
  wq_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_state == DP_WRITE && wq_full) |-> !hready);

  // R9
  rreq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_push |-> !rreq_full);

  // R9
  rreq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_push |=> !rreq_push);

  // R9
  rdat_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdat_pop |-> (!rdat_empty && hready));

  // R10
  unselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && !hsel) |=> !(wq_push || rreq_push));

  // R3
  size_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hsel && htrans[1] && hsize > 3'd2) |-> !beat_accept);

  // R4
  incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_accept && !burst_wraps(gen_burst)) |->
      (beat_addr - gen_prev_addr) == (ADDR_W'(1) << gen_size));

  // R5
  wrap_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_accept && burst_wraps(gen_burst)) |->
      (((beat_addr ^ gen_prev_addr) & ~(span - ADDR_W'(1))) == '0));

endmodule

bind burst_slave_seq burst_slave_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .hsel          (hsel),
  .htrans        (htrans),
  .hsize         (hsize),
  .hready        (hready),
  .wq_push       (wq_push),
  .wq_full       (wq_full),
  .rreq_push     (rreq_push),
  .rreq_full     (rreq_full),
  .rdat_pop      (rdat_pop),
  .rdat_empty    (rdat_empty),
  .beat_accept   (beat_accept),
  .seq_accept    (seq_accept),
  .beat_addr     (beat_addr),
  .gen_prev_addr (gen_prev_addr),
  .gen_size      (gen_size),
  .gen_burst     (gen_burst),
  .dp_state      (dp_state)
);

// File: tb/sim_burst_slave_seq.sv
module sim_burst_slave_seq;

  localparam logic [1:0] T_IDLE = 2'b00;
  localparam logic [1:0] T_BUSY = 2'b01;
  localparam logic [1:0] T_NS   = 2'b10;
  localparam logic [1:0] T_SEQ  = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel = 1'b0;
  logic [1:0]  htrans = T_IDLE;
  logic [2:0]  hburst = 3'd0;
  logic [2:0]  hsize = 3'd0;
  logic        hwrite = 1'b0;
  logic [31:0] haddr = '0;
  logic [31:0] hwdata = '0;
  logic        hready;
  logic [31:0] hrdata;
  logic        wq_push;
  logic [31:0] wq_addr;
  logic [31:0] wq_data;
  logic [2:0]  wq_size;
  logic        wq_full = 1'b0;
  logic        rreq_push;
  logic [31:0] rreq_addr;
  logic [2:0]  rreq_size;
  logic        rreq_full = 1'b0;
  logic        rdat_pop;
  logic [31:0] rdat_data;
  logic        rdat_empty;

  always #2.5 clk = ~clk;

  burst_slave_seq #(.ADDR_W(32), .DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .htrans(htrans), .hburst(hburst),
    .hsize(hsize), .hwrite(hwrite), .haddr(haddr), .hwdata(hwdata),
    .hready(hready), .hrdata(hrdata), .wq_push(wq_push), .wq_addr(wq_addr),
    .wq_data(wq_data), .wq_size(wq_size), .wq_full(wq_full),
    .rreq_push(rreq_push), .rreq_addr(rreq_addr), .rreq_size(rreq_size),
    .rreq_full(rreq_full), .rdat_pop(rdat_pop), .rdat_data(rdat_data),
    .rdat_empty(rdat_empty)
  );

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [2:0]  s;
  } item_t;

  item_t       wq_exp[$];
  item_t       rq_exp[$];
  logic [31:0] rd_exp[$];
  logic [31:0] mem_q[$];

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  logic [31:0] pend_wd = '0;
  logic  hold_rd = 1'b0;
  logic  rd_avail = 1'b0;
  logic [31:0] rd_head = '0;
  bit    done = 1'b0;

  assign rdat_empty = !rd_avail || hold_rd;
  assign rdat_data  = rd_head;

  function automatic logic [31:0] rfun(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Read side model of the queues across the crossing.
  always @(posedge clk) begin
    if (rreq_push) mem_q.push_back(rfun(rreq_addr));
    if (rdat_pop && mem_q.size() > 0) void'(mem_q.pop_front());
    rd_avail <= (mem_q.size() > 0);
    rd_head  <= (mem_q.size() > 0) ? mem_q[0] : 32'h0;
  end

  // Monitor: compare what the design produces against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wq_push) begin
        if (wq_full) chk(0, "R8", "push while full", 32'h1, 32'h0);
        if (wq_exp.size() == 0) chk(0, cur_req, "unexpected write push", wq_addr, 32'h0);
        else begin
          item_t e;
          e = wq_exp.pop_front();
          chk(wq_addr == e.a, cur_req, "write address", wq_addr, e.a);
          chk(wq_data == e.d, "R8", "write data", wq_data, e.d);
          chk(wq_size == e.s, "R3", "write size", {29'h0, wq_size}, {29'h0, e.s});
        end
      end
      if (rreq_push) begin
        if (rq_exp.size() == 0) chk(0, cur_req, "unexpected read request", rreq_addr, 32'h0);
        else begin
          item_t e;
          e = rq_exp.pop_front();
          chk(rreq_addr == e.a, cur_req, "read address", rreq_addr, e.a);
          chk(rreq_size == e.s, "R9", "read size", {29'h0, rreq_size}, {29'h0, e.s});
        end
      end
      if (rdat_pop) begin
        if (rd_exp.size() == 0) chk(0, "R9", "unexpected pop", hrdata, 32'h0);
        else begin
          logic [31:0] d;
          d = rd_exp.pop_front();
          chk(hrdata == d && hready, "R9", "read data", hrdata, d);
        end
      end
    end
  end

  // One address phase; holds until the slave is ready.
  task automatic cyc(input logic [1:0] tr, input logic sel, input logic [31:0] a,
                     input logic [2:0] b, input logic [2:0] s, input logic w,
                     input logic [31:0] wd);
    hsel = sel; htrans = tr; haddr = a; hburst = b; hsize = s; hwrite = w;
    hwdata = pend_wd;
    do @(negedge clk); while (!hready);
    @(posedge clk); #1;
    pend_wd = wd;
  endtask

  task automatic expect_beat(input logic [31:0] a, input logic [2:0] s,
                             input logic w, input logic [31:0] d);
    item_t e;
    e.a = a; e.d = d; e.s = s;
    if (w) wq_exp.push_back(e);
    else begin
      rq_exp.push_back(e);
      rd_exp.push_back(rfun(a));
    end
  endtask

  function automatic int bench_beats(input logic [2:0] b);
    case (b)
      3'd0: return 1;
      3'd1: return 0;
      3'd2, 3'd3: return 4;
      3'd4, 3'd5: return 8;
      default: return 16;
    endcase
  endfunction

  // Burst driver: computes the addresses from the requirements, pushes
  // them into the scoreboard and drives junk on haddr for SEQ beats.
  task automatic burst(input logic [2:0] b, input logic [2:0] s,
                       input logic [31:0] start, input int n, input logic w);
    logic [31:0] step, total, base, a, d;
    bit wr;
    step  = 32'd1 << s;
    total = step * 32'(bench_beats(b));
    wr    = (b != 3'd0) && (b[0] == 1'b0);
    base  = wr ? (start - (start % total)) : start;
    a = start;
    for (int i = 0; i < n; i++) begin
      d = {8'hD0 + 8'(i), a[23:0]};
      expect_beat(a, s, w, d);
      cyc((i == 0) ? T_NS : T_SEQ, 1'b1, (i == 0) ? start : (32'hBAD0_0000 | 32'(i)),
          b, s, w, d);
      if (wr) a = base + ((a - base + step) % total);
      else    a = a + step;
    end
  endtask

  task automatic drain();
    cyc(T_IDLE, 1'b1, 32'h0, 3'd0, 3'd2, 1'b0, 32'h0);
    cyc(T_IDLE, 1'b1, 32'h0, 3'd0, 3'd2, 1'b0, 32'h0);
    repeat (6) @(negedge clk);
    chk(wq_exp.size() == 0 && rq_exp.size() == 0 && rd_exp.size() == 0,
        cur_req, "scoreboard drained",
        32'(wq_exp.size() + rq_exp.size() + rd_exp.size()), 32'h0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset values
    @(negedge clk);
    chk(hready == 1'b1, "R1", "hready in reset", {31'h0, hready}, 32'h1);
    chk(!wq_push && !rreq_push && !rdat_pop, "R1", "strobes in reset",
        {29'h0, wq_push, rreq_push, rdat_pop}, 32'h0);
    repeat (2) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(hready && !wq_push && !rreq_push && !rdat_pop, "R1", "after reset",
        {28'h0, hready, wq_push, rreq_push, rdat_pop}, 32'h8);
    @(posedge clk); #1;

    // R4: incrementing bursts of several sizes and lengths
    cur_req = "R4";
    burst(3'd3, 3'd2, 32'h0000_0100, 4, 1'b1);
    burst(3'd5, 3'd1, 32'h0000_0202, 8, 1'b1);
    burst(3'd7, 3'd0, 32'h0000_03F3, 16, 1'b0);
    drain();

    // R2: beat beyond the count of a fixed burst, and a single transfer
    cur_req = "R2";
    burst(3'd3, 3'd2, 32'h0000_0A00, 4, 1'b1);
    cyc(T_SEQ, 1'b1, 32'h0000_0A10, 3'd3, 3'd2, 1'b1, 32'hEEEE_0001);
    burst(3'd0, 3'd2, 32'h0000_0040, 1, 1'b1);
    cyc(T_SEQ, 1'b1, 32'h0000_0044, 3'd0, 3'd2, 1'b1, 32'hEEEE_0002);
    burst(3'd1, 3'd2, 32'h0000_0B00, 6, 1'b1);
    drain();

    // R5: wrapping bursts, including the top of the address space
    cur_req = "R5";
    burst(3'd2, 3'd2, 32'h0000_0038, 4, 1'b1);
    burst(3'd4, 3'd1, 32'h0000_001E, 8, 1'b1);
    burst(3'd6, 3'd0, 32'h0000_002D, 16, 1'b0);
    burst(3'd6, 3'd2, 32'h0000_0934, 16, 1'b0);
    burst(3'd2, 3'd2, 32'hFFFF_FFF8, 4, 1'b1);
    drain();

    // R6: NONSEQ in mid burst restarts from its own address
    cur_req = "R6";
    burst(3'd5, 3'd2, 32'h0000_0500, 3, 1'b1);
    burst(3'd3, 3'd2, 32'h0000_0600, 4, 1'b1);
    drain();

    // R7: BUSY holds the address; IDLE ends the burst
    cur_req = "R7";
    expect_beat(32'h0000_0C00, 3'd2, 1'b1, 32'h7000_0000);
    cyc(T_NS, 1'b1, 32'h0000_0C00, 3'd3, 3'd2, 1'b1, 32'h7000_0000);
    expect_beat(32'h0000_0C04, 3'd2, 1'b1, 32'h7000_0001);
    cyc(T_SEQ, 1'b1, 32'h0, 3'd3, 3'd2, 1'b1, 32'h7000_0001);
    cyc(T_BUSY, 1'b1, 32'h0, 3'd3, 3'd2, 1'b1, 32'h7777_7777);
    cyc(T_BUSY, 1'b1, 32'h0, 3'd3, 3'd2, 1'b1, 32'h7777_7777);
    expect_beat(32'h0000_0C08, 3'd2, 1'b1, 32'h7000_0002);
    cyc(T_SEQ, 1'b1, 32'h0, 3'd3, 3'd2, 1'b1, 32'h7000_0002);
    expect_beat(32'h0000_0C0C, 3'd2, 1'b1, 32'h7000_0003);
    cyc(T_SEQ, 1'b1, 32'h0, 3'd3, 3'd2, 1'b1, 32'h7000_0003);
    burst(3'd1, 3'd2, 32'h0000_0D00, 3, 1'b1);
    cyc(T_IDLE, 1'b1, 32'h0, 3'd1, 3'd2, 1'b1, 32'h0);
    cyc(T_SEQ, 1'b1, 32'h0000_0D0C, 3'd1, 3'd2, 1'b1, 32'hEEEE_0003);
    drain();

    // R3: size codes above word are refused and end the burst
    cur_req = "R3";
    burst(3'd1, 3'd2, 32'h0000_0E00, 2, 1'b1);
    cyc(T_SEQ, 1'b1, 32'h0, 3'd1, 3'd3, 1'b1, 32'hEEEE_0004);
    cyc(T_SEQ, 1'b1, 32'h0, 3'd1, 3'd2, 1'b1, 32'hEEEE_0005);
    cyc(T_NS, 1'b1, 32'h0000_0F00, 3'd3, 3'd4, 1'b1, 32'hEEEE_0006);
    cyc(T_SEQ, 1'b1, 32'h0, 3'd3, 3'd4, 1'b1, 32'hEEEE_0007);
    drain();

    // R10: unselected transfers reach no queue
    cur_req = "R10";
    cyc(T_NS, 1'b0, 32'h0000_1000, 3'd3, 3'd2, 1'b1, 32'hEEEE_0008);
    cyc(T_NS, 1'b0, 32'h0000_1000, 3'd3, 3'd2, 1'b0, 32'hEEEE_0009);
    @(negedge clk);
    chk(!wq_push && !rreq_push, "R10", "no push when unselected",
        {30'h0, wq_push, rreq_push}, 32'h0);
    @(posedge clk); #1;
    drain();

    // R8: write stall on a full write queue
    cur_req = "R8";
    wq_full = 1'b1;
    fork
      burst(3'd3, 3'd2, 32'h0000_0700, 4, 1'b1);
      begin
        @(negedge clk);
        @(negedge clk);
        chk(hready == 1'b0, "R8", "stall while full", {31'h0, hready}, 32'h0);
        @(negedge clk);
        chk(hready == 1'b0 && !wq_push, "R8", "still stalled",
            {30'h0, hready, wq_push}, 32'h0);
        @(posedge clk); #1;
        wq_full = 1'b0;
      end
    join
    drain();

    // R9: read stalls on a full request queue and an empty data queue
    cur_req = "R9";
    rreq_full = 1'b1;
    hold_rd = 1'b1;
    fork
      burst(3'd0, 3'd2, 32'h0000_0804, 1, 1'b0);
      begin
        @(negedge clk);
        @(negedge clk);
        chk(!hready && !rreq_push, "R9", "request held while full",
            {30'h0, hready, rreq_push}, 32'h0);
        @(negedge clk);
        chk(!hready && !rreq_push, "R9", "request still held",
            {30'h0, hready, rreq_push}, 32'h0);
        @(posedge clk); #1;
        rreq_full = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!hready && !rdat_pop, "R9", "wait for read data",
            {30'h0, hready, rdat_pop}, 32'h0);
        @(posedge clk); #1;
        hold_rd = 1'b0;
      end
    join
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule